// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block runs once after reset and walks a DDR2 SDRAM device from power-up to a usable state. It holds the clock enable low for the power-stabilization interval, raises it, and waits a short settling time. It then drives a fixed series of precharge-all, refresh and mode-register-load commands onto the command, bank-address and address pins. NOP fills every cycle between two commands. When the last load has gone out, the block raises a done flag and keeps the bus idle.

The contents of the four mode registers come from static configuration inputs, one 13-bit field per register. The sequencer forces the bits that belong to the initialization procedure itself: the DLL enable and the off-chip driver calibration field of the first extended register, and the DLL reset bit of the base register. The two wall-clock delays are derived from a clock-frequency parameter and rounded up. The command spacings are parameters counted in clock cycles.

Top module: `ddr2_powerup_seq`

## Requirements
- R1: While reset is asserted, cke is 0, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), ba and addr are 0 and init_done is 0.
- R2: After reset release, cke stays 0 for ceil(200 us x clock frequency) cycles, with NOP on the command pins throughout. cke then goes to 1 and never returns to 0 until the next reset.
- R3: After cke rises, NOP is held for ceil(400 ns x clock frequency) cycles. The first command is then PRECHARGE ALL, encoded 0010 with addr[10] = 1.
- R4: The eleven commands appear in this order: PRECHARGE ALL; loads of EMR2, EMR3, EMR1 and MR (DLL reset); PRECHARGE ALL; two REFRESH (0001); then loads of MR, EMR1 (calibration default) and EMR1 (calibration exit). A load is encoded 0000.
- R5: During each load, ba[1:0] selects the target register (MR 00, EMR1 01, EMR2 10, EMR3 11), and ba[2] and addr[15:13] are 0.
- R6: The MR load that resets the DLL drives addr = 0x0100 (only A8 set), whatever the configuration inputs hold.
- R7: Every EMR1 load carries the EMR1 configuration with A0 forced to 0 (DLL enabled). A9:7 is 111 on the calibration-default load and 000 on the other two EMR1 loads.
- R8: The EMR2 and EMR3 loads carry their configuration fields unchanged. The final MR load carries the MR configuration with A8 forced to 0.
- R9: The distance in cycles from one command to the next is T_RP after a precharge, T_MRD after a load, T_RFC after a refresh, and DLL_WAIT after the DLL-reset load. Only NOP appears in between.
- R10: init_done rises in the cycle after the calibration-exit load. From then on it stays 1, with cke at 1 and NOP on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the sequence on release |
| mr_cfg | input | 13 | Base mode register contents (A8 is overridden) |
| emr1_cfg | input | 13 | Extended register 1 contents (A0 and A9:7 are overridden) |
| emr2_cfg | input | 13 | Extended register 2 contents |
| emr3_cfg | input | 13 | Extended register 3 contents |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ADDR_W | Address bus / mode register value |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The full sequence runs with two configuration sets. In the first, the EMR1 field has A0 and all of A9:7 set, and the MR field has A8 clear. The second uses all-ones MR, all-zero EMR1 and alternating patterns in EMR2 and EMR3. Together they separate forced bits from passed-through bits, and they catch swapped or mis-targeted register fields. The clock frequency is chosen so that both wall-clock delays need rounding up, and the spacing parameters differ from one another, so a wrong spacing rule or a truncated delay changes the measured cycle counts. A reset in the middle of the DLL wait confirms that the outputs return to their idle values and that the sequence starts again from the beginning.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

   localparam int MODE_W  = 13;
   localparam int N_STEPS = 11;

   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } ddr_cmd_e;

   typedef enum logic [1:0] {
      SEL_MR   = 2'b00,
      SEL_EMR1 = 2'b01,
      SEL_EMR2 = 2'b10,
      SEL_EMR3 = 2'b11
   } mreg_sel_e;

   typedef enum logic [2:0] {
      PAY_NONE,
      PAY_A10,
      PAY_EXT2,
      PAY_EXT3,
      PAY_EXT1_OCDOFF,
      PAY_DLLRST,
      PAY_BASE,
      PAY_EXT1_OCDDEF
   } payload_e;

   typedef enum logic [1:0] {
      GAP_RP,
      GAP_MRD,
      GAP_DLL,
      GAP_RFC
   } gap_e;

   typedef struct packed {
      ddr_cmd_e  cmd;
      mreg_sel_e sel;
      payload_e  pay;
      gap_e      gap;
   } step_t;

   // gap field = spacing that follows this step
   function automatic step_t step_of(input logic [3:0] idx);
      step_t s;
      case (idx)
         4'd0:    s = '{CMD_PRE, SEL_MR,   PAY_A10,         GAP_RP };
         4'd1:    s = '{CMD_LMR, SEL_EMR2, PAY_EXT2,        GAP_MRD};
         4'd2:    s = '{CMD_LMR, SEL_EMR3, PAY_EXT3,        GAP_MRD};
         4'd3:    s = '{CMD_LMR, SEL_EMR1, PAY_EXT1_OCDOFF, GAP_MRD};
         4'd4:    s = '{CMD_LMR, SEL_MR,   PAY_DLLRST,      GAP_DLL};
         4'd5:    s = '{CMD_PRE, SEL_MR,   PAY_A10,         GAP_RP };
         4'd6:    s = '{CMD_REF, SEL_MR,   PAY_NONE,        GAP_RFC};
         4'd7:    s = '{CMD_REF, SEL_MR,   PAY_NONE,        GAP_RFC};
         4'd8:    s = '{CMD_LMR, SEL_MR,   PAY_BASE,        GAP_MRD};
         4'd9:    s = '{CMD_LMR, SEL_EMR1, PAY_EXT1_OCDDEF, GAP_MRD};
         4'd10:   s = '{CMD_LMR, SEL_EMR1, PAY_EXT1_OCDOFF, GAP_MRD};
         default: s = '{CMD_NOP, SEL_MR,   PAY_NONE,        GAP_MRD};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   if (RST_VAL < 0 || RST_VAL >= (2 ** CNT_W)) begin : g_bad_rst
      $error("ddr2_init_timer: RST_VAL does not fit CNT_W");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_payload.sv
module ddr2_init_payload
   import ddr2_init_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BA_W   = 3
) (
   input  logic              active,
   input  step_t             step,
   input  logic [MODE_W-1:0] mr_cfg,
   input  logic [MODE_W-1:0] emr1_cfg,
   input  logic [MODE_W-1:0] emr2_cfg,
   input  logic [MODE_W-1:0] emr3_cfg,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [MODE_W-1:0] OCD_MASK  = MODE_W'(13'h0380);
   localparam logic [MODE_W-1:0] DLL_OFF   = MODE_W'(13'h0001);
   localparam logic [MODE_W-1:0] DLL_RST   = MODE_W'(13'h0100);
   localparam logic [MODE_W-1:0] PRE_ALL   = MODE_W'(13'h0400);

   logic [MODE_W-1:0] field;
   logic [MODE_W-1:0] emr1_base;
   logic              is_load;

   assign emr1_base = emr1_cfg & ~(OCD_MASK | DLL_OFF);
   assign is_load   = active && (step.cmd == CMD_LMR);

   always_comb begin
      case (step.pay)
         PAY_A10:         field = PRE_ALL;
         PAY_EXT2:        field = emr2_cfg;
         PAY_EXT3:        field = emr3_cfg;
         PAY_EXT1_OCDOFF: field = emr1_base;
         PAY_EXT1_OCDDEF: field = emr1_base | OCD_MASK;
         PAY_DLLRST:      field = DLL_RST;
         PAY_BASE:        field = mr_cfg & ~DLL_RST;
         default:         field = '0;
      endcase
   end

   if (ADDR_W > MODE_W) begin : g_addr_pad
      assign addr = active ? {{(ADDR_W-MODE_W){1'b0}}, field} : '0;
   end else begin : g_addr_flat
      assign addr = active ? field : '0;
   end

   if (BA_W > 2) begin : g_ba_pad
      assign ba = is_load ? {{(BA_W-2){1'b0}}, step.sel} : '0;
   end else begin : g_ba_flat
      assign ba = is_load ? step.sel : '0;
   end

endmodule

// File: rtl/ddr2_powerup_seq.sv
module ddr2_powerup_seq
   import ddr2_init_pkg::*;
#(
   parameter int CLK_FREQ_KHZ = 200000,
   parameter int ADDR_W       = 16,
   parameter int BA_W         = 3,
   parameter int T_MRD        = 2,
   parameter int T_RP         = 3,
   parameter int T_RFC        = 26,
   parameter int DLL_WAIT     = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [12:0]       mr_cfg,
   input  logic [12:0]       emr1_cfg,
   input  logic [12:0]       emr2_cfg,
   input  logic [12:0]       emr3_cfg,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   // wall-clock delays rounded up to whole cycles
   localparam int PWR_CYC = (200 * CLK_FREQ_KHZ + 999) / 1000;
   localparam int CKE_CYC = (400 * CLK_FREQ_KHZ + 999999) / 1000000;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int MAX_CYC = imax(imax(PWR_CYC, CKE_CYC),
                                 imax(imax(DLL_WAIT, T_RFC), imax(T_RP, T_MRD)));
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [3:0] LAST_STEP = 4'(N_STEPS - 1);

   if (CLK_FREQ_KHZ < 1)            begin : g_bad_freq $error("CLK_FREQ_KHZ must be positive"); end
   if (ADDR_W < MODE_W)             begin : g_bad_addr $error("ADDR_W narrower than mode field"); end
   if (BA_W < 2)                    begin : g_bad_ba   $error("BA_W must be at least 2"); end
   if (T_MRD < 2 || T_RP < 2 || T_RFC < 2) begin : g_bad_gap $error("command spacings must be >= 2"); end
   if (DLL_WAIT < 200 || DLL_WAIT < T_MRD) begin : g_bad_dll $error("DLL_WAIT below minimum"); end

   typedef enum logic [2:0] {ST_PWR, ST_CKE, ST_CMD, ST_GAP, ST_DONE} seq_state_e;

   seq_state_e       state_q, state_d;
   logic [3:0]       step_q, step_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   step_t            cur;
   ddr_cmd_e         cmd_out;

   assign cur = step_of(step_q);

   function automatic logic [CNT_W-1:0] gap_load(input gap_e g);
      case (g)
         GAP_RP:  return CNT_W'(T_RP - 2);
         GAP_RFC: return CNT_W'(T_RFC - 2);
         GAP_DLL: return CNT_W'(DLL_WAIT - 2);
         default: return CNT_W'(T_MRD - 2);
      endcase
   endfunction

   ddr2_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (PWR_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      step_d   = step_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_PWR: if (tmr_zero) begin
            state_d  = ST_CKE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(CKE_CYC - 1);
         end
         ST_CKE: if (tmr_zero) begin
            state_d = ST_CMD;
            step_d  = '0;
         end
         ST_CMD: begin
            if (step_q == LAST_STEP) begin
               state_d = ST_DONE;
            end else begin
               state_d  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = gap_load(cur.gap);
            end
         end
         ST_GAP: if (tmr_zero) begin
            state_d = ST_CMD;
            step_d  = step_q + 4'd1;
         end
         default: state_d = ST_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PWR;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   ddr2_init_payload #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W)
   ) u_payload (
      .active   (state_q == ST_CMD),
      .step     (cur),
      .mr_cfg   (mr_cfg),
      .emr1_cfg (emr1_cfg),
      .emr2_cfg (emr2_cfg),
      .emr3_cfg (emr3_cfg),
      .ba       (ba),
      .addr     (addr)
   );

   assign cmd_out = (state_q == ST_CMD) ? cur.cmd : CMD_NOP;
   assign {cs_n, ras_n, cas_n, we_n} = cmd_out;
   assign cke       = (state_q != ST_PWR);
   assign init_done = (state_q == ST_DONE);

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
   parameter int ADDR_W = 16,
   parameter int BA_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);

   logic [3:0] cmd;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   // R2
   idle_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cmd == 4'b0111);

   // R3
   pre_all_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 4'b0010 |-> addr[10]);

   // R5
   load_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 4'b0000 |-> (ba[BA_W-1:2] == '0 && addr[ADDR_W-1:13] == '0));

   // R6
   dll_reset_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000 && ba[1:0] == 2'b00 && addr[8]) |-> addr == ADDR_W'(16'h0100));

   // R9
   spacing_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd != 4'b0111 |=> cmd == 4'b0111);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R10
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cke && cmd == 4'b0111));

endmodule

bind ddr2_powerup_seq ddr2_init_chk #(
   .ADDR_W (ADDR_W),
   .BA_W   (BA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/sim_ddr2_powerup_seq.sv
module sim_ddr2_powerup_seq;

   localparam int CLK_PERIOD = 10;
   localparam int FREQ_KHZ   = 33333;
   // 200 us * 33.333 MHz = 6666.6 -> 6667 ; 400 ns * 33.333 MHz = 13.33 -> 14
   localparam int EXP_PWR    = 6667;
   localparam int EXP_CKE    = 14;
   localparam int P_MRD      = 2;
   localparam int P_RP       = 3;
   localparam int P_RFC      = 9;
   localparam int P_DLL      = 200;

   localparam logic [3:0] C_LMR = 4'b0000;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_NOP = 4'b0111;

   // payload kinds used by the bench
   localparam logic [2:0] K_PRE = 3'd0, K_REF = 3'd1, K_E2 = 3'd2, K_E3 = 3'd3,
                          K_E1OFF = 3'd4, K_DLL = 3'd5, K_MR = 3'd6, K_E1DEF = 3'd7;

   // {cmd, ba[1:0], kind, gap before this command}
   localparam logic [16:0] VEC [11] = '{
      {C_PRE, 2'b00, K_PRE,   8'd0},
      {C_LMR, 2'b10, K_E2,    8'(P_RP)},
      {C_LMR, 2'b11, K_E3,    8'(P_MRD)},
      {C_LMR, 2'b01, K_E1OFF, 8'(P_MRD)},
      {C_LMR, 2'b00, K_DLL,   8'(P_MRD)},
      {C_PRE, 2'b00, K_PRE,   8'(P_DLL)},
      {C_REF, 2'b00, K_REF,   8'(P_RP)},
      {C_REF, 2'b00, K_REF,   8'(P_RFC)},
      {C_LMR, 2'b00, K_MR,    8'(P_RFC)},
      {C_LMR, 2'b01, K_E1DEF, 8'(P_MRD)},
      {C_LMR, 2'b01, K_E1OFF, 8'(P_MRD)}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] mr_cfg = '0, emr1_cfg = '0, emr2_cfg = '0, emr3_cfg = '0;
   logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [2:0]  ba;
   logic [15:0] addr;
   logic [3:0]  cmd;

   int n_cmp = 0;
   int n_bad = 0;

   assign cmd = {cs_n, ras_n, cas_n, we_n};

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr2_powerup_seq #(
      .CLK_FREQ_KHZ (FREQ_KHZ),
      .ADDR_W       (16),
      .BA_W         (3),
      .T_MRD        (P_MRD),
      .T_RP         (P_RP),
      .T_RFC        (P_RFC),
      .DLL_WAIT     (P_DLL)
   ) u0 (
      .clk (clk), .rst_n (rst_n),
      .mr_cfg (mr_cfg), .emr1_cfg (emr1_cfg), .emr2_cfg (emr2_cfg), .emr3_cfg (emr3_cfg),
      .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .ba (ba), .addr (addr), .init_done (init_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [2:0] kind);
      logic [12:0] e1b;
      e1b = emr1_cfg & ~13'h0381;
      case (kind)
         K_PRE:   return 16'h0400;
         K_E2:    return {3'b000, emr2_cfg};
         K_E3:    return {3'b000, emr3_cfg};
         K_E1OFF: return {3'b000, e1b};
         K_E1DEF: return {3'b000, e1b | 13'h0380};
         K_DLL:   return 16'h0100;
         K_MR:    return {3'b000, mr_cfg & ~13'h0100};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check_reset_state();
      chk("R1 reset cke", {31'd0, cke}, 32'd0);
      chk("R1 reset command", {28'd0, cmd}, {28'd0, C_NOP});
      chk("R1 reset ba/addr", {13'd0, ba, addr}, 32'd0);
      chk("R1 reset init_done", {31'd0, init_done}, 32'd0);
   endtask

   task automatic run_pattern(input logic [12:0] m, input logic [12:0] e1,
                              input logic [12:0] e2, input logic [12:0] e3);
      int lo, hi, gap, hold_bad, idle_bad;
      mr_cfg = m; emr1_cfg = e1; emr2_cfg = e2; emr3_cfg = e3;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      lo = 0; idle_bad = 0; hold_bad = 0;
      while (cke === 1'b0 && lo < 20000) begin
         if (cmd !== C_NOP) idle_bad++;
         lo++;
         @(negedge clk);
      end
      chk("R2 cke low cycles", lo, EXP_PWR);
      chk("R2 NOP while cke low", idle_bad, 0);
      hi = 0;
      while (cmd === C_NOP && hi < 1000) begin
         hi++;
         @(negedge clk);
      end
      chk("R3 settle cycles after cke", hi, EXP_CKE);
      for (int k = 0; k < 11; k++) begin
         if (k > 0) begin
            gap = 0;
            do begin
               @(negedge clk);
               gap++;
               if (cke !== 1'b1) hold_bad++;
            end while (cmd === C_NOP && gap < 1000);
            chk($sformatf("R9 spacing before step %0d", k), gap, {24'd0, VEC[k][7:0]});
         end
         chk($sformatf("R4 command at step %0d", k), {28'd0, cmd}, {28'd0, VEC[k][16:13]});
         if (VEC[k][16:13] == C_LMR)
            chk($sformatf("R5 ba at step %0d", k), {29'd0, ba}, {29'd0, 1'b0, VEC[k][12:11]});
         if (VEC[k][10:8] != K_REF)
            chk($sformatf("R6 R7 R8 addr at step %0d", k), {16'd0, addr}, {16'd0, exp_addr(VEC[k][10:8])});
         chk($sformatf("R10 done low at step %0d", k), {31'd0, init_done}, 32'd0);
      end
      @(negedge clk);
      chk("R10 done after calibration exit", {31'd0, init_done}, 32'd1);
      for (int i = 0; i < 20; i++) begin
         if (init_done !== 1'b1 || cmd !== C_NOP || cke !== 1'b1) idle_bad++;
         @(negedge clk);
      end
      chk("R10 quiet after done", idle_bad, 0);
      chk("R2 cke held high", hold_bad, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      check_reset_state();
      // forced bits set in EMR1, A8 clear in MR
      run_pattern(13'h0A53, 13'h1385, 13'h0080, 13'h0000);
      // all-ones MR, zero EMR1, alternating extended patterns
      run_pattern(13'h1FFF, 13'h0000, 13'h0AAA, 13'h1555);
      // reset during the DLL wait, then a clean restart
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (EXP_PWR + EXP_CKE + 40) @(negedge clk);
      chk("R1 mid-run state before reset", {31'd0, cke}, 32'd1);
      rst_n = 1'b0;
      #1;
      check_reset_state();
      run_pattern(13'h0642, 13'h0044, 13'h0001, 13'h1000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule